// File: doc/BRIEF.md
# Transmit Bit Clock Generator

This block makes the bit-rate timing for a transmit path. It divides the system clock by two programmable dividers in series and then by a fixed power of two, 32 by default. The result is a square data clock that a host uses to present transmit bits. In the same cycle that the data clock goes high, the block pulses a one-cycle bit strobe and captures the host's transmit bit into a register, which feeds the modulator.

Both divider values come from one configuration word. A 4-bit demodulator-rate field and an 8-bit clock-recovery field are extracted from it. A field value of zero is treated as one. The block copies the divider values into internal registers only at the end of a data-clock period. A change to the configuration word therefore never shortens or stretches a period that is already in progress. In the oversampled binary-FSK mode the host times the data itself, so the data clock and the strobe are held low. When that mode is left, the clock stays low until the next rising point of the period.

Top module: `tx_bitclk_gen`

## Requirements
- R1: With effective divider values A and B, the data clock has a period of A·B·2^PH_W system cycles, counted from reset. It is low for the first half of each period and high for the second half.
- R2: The demodulator divider is read from cfg_word bits 9:6 and the clock-recovery divider from cfg_word bits 17:10. No other bit of cfg_word has any effect on the outputs.
- R3: A divider field holding zero acts exactly as a field holding one.
- R4: bit_stb is high for exactly one cycle per period, in the first cycle in which dclk is high, and at no other time.
- R5: At each strobe, txd_q takes the host_txd value present at that clock edge and holds it until the next strobe.
- R6: A change to either divider field takes effect at the next period boundary. The period in progress completes with the old values, and the new period starts from a phase of zero.
- R7: While osamp_mode is high, dclk and bit_stb are low and txd_q holds its value. After osamp_mode falls, dclk stays low until the next rising point of the period; the phase is not disturbed.
- R8: The synchronous active-high reset drives dclk, bit_stb and txd_q low. It restarts the period from zero using the divider fields present during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | CFG_W | Configuration word carrying both divider fields |
| osamp_mode | input | 1 | High in the oversampled binary-FSK mode; suppresses the data clock |
| host_txd | input | 1 | Transmit bit from the host |
| dclk | output | 1 | Square data clock |
| bit_stb | output | 1 | One-cycle pulse at each data-clock rising point |
| txd_q | output | 1 | Transmit bit captured at the last strobe |

## Verification
The bench builds two instances that share every input. The first uses PH_W = 2, a fixed divide-by-4 stage. This keeps periods short enough to sweep all sixteen demodulator field values against several clock-recovery values, including zero and the full 255, with two complete periods each. The second uses the default PH_W = 5. It confirms the factor of 32 at unit dividers and runs through the mid-period reload, suppression and reset sequences on a longer time scale than the first. Expected edges are computed from the field values and the count of cycles since reset.

// File: rtl/tx_bitclk_pkg.sv
package tx_bitclk_pkg;

    // Event that the output stage applies to the data clock this cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } clk_event_e;

endpackage

// File: rtl/tx_bitclk_decode.sv
module tx_bitclk_decode #(
    parameter int CFG_W    = 32,
    parameter int DDIV_LSB = 6,
    parameter int DDIV_W   = 4,
    parameter int RDIV_LSB = 10,
    parameter int RDIV_W   = 8
) (
    input  logic [CFG_W-1:0]  cfg_word,
    output logic [DDIV_W-1:0] ddiv_eff,
    output logic [RDIV_W-1:0] rdiv_eff
);

    logic [DDIV_W-1:0] ddiv_raw;
    logic [RDIV_W-1:0] rdiv_raw;
    logic              unused_cfg_bits;

    assign ddiv_raw = cfg_word[DDIV_LSB +: DDIV_W];
    assign rdiv_raw = cfg_word[RDIV_LSB +: RDIV_W];
    assign unused_cfg_bits = ^cfg_word;

    // zero is promoted to one so the chain never stalls
    always_comb begin
        ddiv_eff = (ddiv_raw == '0) ? DDIV_W'(1) : ddiv_raw;
        rdiv_eff = (rdiv_raw == '0) ? RDIV_W'(1) : rdiv_raw;
    end

endmodule

// File: rtl/tx_bitclk_div.sv
module tx_bitclk_div #(
    parameter int DDIV_W = 4,
    parameter int RDIV_W = 8,
    parameter int PH_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DDIV_W-1:0] ddiv_in,
    input  logic [RDIV_W-1:0] rdiv_in,
    output logic              step,
    output logic              wrap,
    output logic [PH_W-1:0]   phase
);

    typedef struct packed {
        logic [DDIV_W-1:0] cnt_a;
        logic [RDIV_W-1:0] cnt_b;
        logic [PH_W-1:0]   ph;
        logic [DDIV_W-1:0] sh_a;
        logic [RDIV_W-1:0] sh_b;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    a_end;
    logic    b_end;

    always_comb begin
        a_end = (st_q.cnt_a == st_q.sh_a - DDIV_W'(1));
        b_end = (st_q.cnt_b == st_q.sh_b - RDIV_W'(1));
        step  = a_end && b_end;
        wrap  = step && (&st_q.ph);

        st_d       = st_q;
        st_d.cnt_a = a_end ? '0 : st_q.cnt_a + DDIV_W'(1);
        if (a_end) begin
            st_d.cnt_b = b_end ? '0 : st_q.cnt_b + RDIV_W'(1);
        end
        if (step) begin
            st_d.ph = st_q.ph + PH_W'(1);
        end
        // divider values are only adopted at a period boundary
        if (wrap) begin
            st_d.sh_a = ddiv_in;
            st_d.sh_b = rdiv_in;
        end
        if (rst) begin
            st_d      = '0;
            st_d.sh_a = ddiv_in;
            st_d.sh_b = rdiv_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase = st_q.ph;

    // R3
    shadow_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.sh_a != '0) && (st_q.sh_b != '0));

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt_a < st_q.sh_a) && (st_q.cnt_b < st_q.sh_b));

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph != '0) |-> ($stable(st_q.sh_a) && $stable(st_q.sh_b)));

endmodule

// File: rtl/tx_bitclk_out.sv
module tx_bitclk_out
    import tx_bitclk_pkg::*;
#(
    parameter int PH_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic            wrap,
    input  logic [PH_W-1:0] phase,
    input  logic            osamp_mode,
    input  logic            host_txd,
    output logic            dclk,
    output logic            bit_stb,
    output logic            txd_q
);

    localparam logic [PH_W-1:0] RISE_PH = PH_W'((1 << (PH_W - 1)) - 1);

    typedef struct packed {
        logic clk_lvl;
        logic stb;
        logic txd;
    } out_st_t;

    out_st_t    ost_d, ost_q;
    clk_event_e ev;

    always_comb begin
        if (step && (phase == RISE_PH)) begin
            ev = EV_RISE;
        end else if (wrap) begin
            ev = EV_FALL;
        end else begin
            ev = EV_NONE;
        end

        ost_d     = ost_q;
        ost_d.stb = 1'b0;
        case (ev)
            EV_RISE: begin
                ost_d.clk_lvl = 1'b1;
                ost_d.stb     = 1'b1;
                ost_d.txd     = host_txd;
            end
            EV_FALL: ost_d.clk_lvl = 1'b0;
            default: ;
        endcase
        if (osamp_mode) begin
            ost_d.clk_lvl = 1'b0;
            ost_d.stb     = 1'b0;
            ost_d.txd     = ost_q.txd;
        end
        if (rst) begin
            ost_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ost_q <= ost_d;
    end

    assign dclk    = ost_q.clk_lvl;
    assign bit_stb = ost_q.stb;
    assign txd_q   = ost_q.txd;

    // R4
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    // R4
    stb_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> (dclk && !$past(dclk)));

    // R7
    osamp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        osamp_mode |=> (!dclk && !bit_stb));

    // R5
    txd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |-> $stable(txd_q));

    // R1
    fall_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dclk) |-> ((phase == '0) || $past(osamp_mode)));

endmodule

// File: rtl/tx_bitclk_gen.sv
module tx_bitclk_gen #(
    parameter int CFG_W    = 32,
    parameter int DDIV_LSB = 6,
    parameter int DDIV_W   = 4,
    parameter int RDIV_LSB = 10,
    parameter int RDIV_W   = 8,
    parameter int PH_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             osamp_mode,
    input  logic             host_txd,
    output logic             dclk,
    output logic             bit_stb,
    output logic             txd_q
);

    logic [DDIV_W-1:0] ddiv_eff;
    logic [RDIV_W-1:0] rdiv_eff;
    logic              step;
    logic              wrap;
    logic [PH_W-1:0]   phase;

    tx_bitclk_decode #(
        .CFG_W    (CFG_W),
        .DDIV_LSB (DDIV_LSB),
        .DDIV_W   (DDIV_W),
        .RDIV_LSB (RDIV_LSB),
        .RDIV_W   (RDIV_W)
    ) i_decode (
        .cfg_word (cfg_word),
        .ddiv_eff (ddiv_eff),
        .rdiv_eff (rdiv_eff)
    );

    tx_bitclk_div #(
        .DDIV_W (DDIV_W),
        .RDIV_W (RDIV_W),
        .PH_W   (PH_W)
    ) i_div (
        .clk     (clk),
        .rst     (rst),
        .ddiv_in (ddiv_eff),
        .rdiv_in (rdiv_eff),
        .step    (step),
        .wrap    (wrap),
        .phase   (phase)
    );

    tx_bitclk_out #(
        .PH_W (PH_W)
    ) i_out (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .wrap       (wrap),
        .phase      (phase),
        .osamp_mode (osamp_mode),
        .host_txd   (host_txd),
        .dclk       (dclk),
        .bit_stb    (bit_stb),
        .txd_q      (txd_q)
    );

endmodule

// File: tb/test_tx_bitclk_gen.sv
`timescale 1ns/1ps
module test_tx_bitclk_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg = 32'h0;
    logic        osamp = 1'b0;
    logic        host_txd = 1'b0;
    logic        dclk_v [2];
    logic        stb_v  [2];
    logic        txd_v  [2];

    int   m = 0;
    logic os_e = 1'b0;
    logic d_e = 1'b0;

    int   base [2];
    int   dcur [2];
    bit   supp [2];
    bit   exp_txd [2];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    string dtag = "R1";

    always #2.5 clk = ~clk;

    // instance with a divide-by-4 fixed stage
    tx_bitclk_gen #(.PH_W(2)) i_tx_bitclk_gen (
        .clk (clk), .rst (rst), .cfg_word (cfg), .osamp_mode (osamp),
        .host_txd (host_txd), .dclk (dclk_v[0]), .bit_stb (stb_v[0]), .txd_q (txd_v[0])
    );

    // instance with the default divide-by-32 fixed stage
    tx_bitclk_gen i_tx_bitclk_gen_full (
        .clk (clk), .rst (rst), .cfg_word (cfg), .osamp_mode (osamp),
        .host_txd (host_txd), .dclk (dclk_v[1]), .bit_stb (stb_v[1]), .txd_q (txd_v[1])
    );

    always @(posedge clk) begin
        m    <= rst ? 0 : m + 1;
        os_e <= osamp;
        d_e  <= host_txd;
    end

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // R2: demod field bits 9:6, recovery field bits 17:10
    function automatic int dfrom(input logic [31:0] c);
        return eff(int'(c[9:6])) * eff(int'(c[17:10]));
    endfunction

    function automatic logic [31:0] mkcfg(input int da, input int db, input logic [31:0] junk);
        logic [31:0] c;
        c = junk;
        c[9:6]   = 4'(da);
        c[17:10] = 8'(db);
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at m=%0d: actual %0d expected %0d", tag, m, act, exp);
        end
    endtask

    task automatic evaluate();
        for (int i = 0; i < 2; i++) begin
            int  full;
            int  half;
            int  rel;
            bit  rise;
            bit  e_dclk;
            bit  e_stb;
            full = (i == 0) ? 4 : 32;
            half = full / 2;
            rel  = m - base[i];
            if (rel == dcur[i] * full) begin
                // R6: new field values adopted at the boundary
                base[i] = m;
                dcur[i] = dfrom(cfg);
                rel     = 0;
            end
            rise = (rel == dcur[i] * half);
            if (os_e) begin
                supp[i] = 1'b1;
                e_dclk  = 1'b0;
                e_stb   = 1'b0;
            end else if (rise) begin
                supp[i]    = 1'b0;
                e_dclk     = 1'b1;
                e_stb      = 1'b1;
                exp_txd[i] = d_e;
            end else begin
                e_stb  = 1'b0;
                e_dclk = supp[i] ? 1'b0 : ((rel / dcur[i]) >= half);
            end
            chk(dclk_v[i] == e_dclk, supp[i] ? "R7 dclk" : dtag, int'(dclk_v[i]), int'(e_dclk));
            chk(stb_v[i] == e_stb, "R4 bit_stb", int'(stb_v[i]), int'(e_stb));
            chk(txd_v[i] == exp_txd[i], "R5 txd_q", int'(txd_v[i]), int'(exp_txd[i]));
        end
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            evaluate();
            host_txd = m[0] ^ m[2] ^ m[3];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            // R8: outputs cleared under reset
            chk(dclk_v[i] == 1'b0, "R8 dclk", int'(dclk_v[i]), 0);
            chk(stb_v[i] == 1'b0, "R8 bit_stb", int'(stb_v[i]), 0);
            chk(txd_v[i] == 1'b0, "R8 txd_q", int'(txd_v[i]), 0);
            base[i]    = 0;
            dcur[i]    = dfrom(cfg);
            supp[i]    = 1'b0;
            exp_txd[i] = 1'b0;
        end
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int dbs [6];
        dbs = '{0, 1, 2, 3, 7, 0};

        // R1 R2 R3: sweep every demod value against several recovery values
        dtag = "R1 dclk";
        for (int da = 0; da < 16; da++) begin
            for (int k = 0; k < 5; k++) begin
                cfg = mkcfg(da, dbs[k], 32'hA5C3_96F0 ^ (32'(da) * 32'h0101_0101));
                do_reset();
                run(2 * dfrom(cfg) * 4 + 3);
            end
        end

        // R3: both fields zero on the divide-by-32 instance gives period 32
        dtag = "R3 dclk";
        cfg = mkcfg(0, 0, 32'h0);
        do_reset();
        run(2 * 32 + 3);

        // R1: widest recovery field
        dtag = "R1 dclk wide";
        cfg = mkcfg(1, 255, 32'hFFFF_FFFF);
        do_reset();
        run(2 * 255 * 4 + 3);

        // R2: toggling bits outside the fields changes nothing
        dtag = "R2 dclk";
        cfg = mkcfg(2, 3, 32'h1234_5678);
        do_reset();
        run(30);
        cfg = cfg ^ 32'hFFFC_003F;
        run(100);
        cfg = cfg ^ 32'hFFFC_003F;
        run(50);

        // R6: mid-period field change waits for the boundary
        dtag = "R6 dclk";
        cfg = mkcfg(3, 2, 32'h0);
        do_reset();
        run(5);
        cfg = mkcfg(1, 5, 32'h0);
        run(400);
        cfg = mkcfg(0, 1, 32'h0);
        run(200);

        // R7: suppression in the oversampled mode, then resume at a rising point
        dtag = "R7 dclk";
        cfg = mkcfg(2, 1, 32'h0);
        do_reset();
        run(10);
        osamp = 1'b1;
        run(30);
        osamp = 1'b0;
        run(200);

        // R8: reset in the middle of a run restarts the period
        dtag = "R8 dclk";
        cfg = mkcfg(1, 1, 32'h0);
        do_reset();
        run(7);
        cfg = mkcfg(2, 2, 32'h0);
        do_reset();
        run(300);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule